// File: doc/BRIEF.md
# Start-up inter-processor command sequencer

This block wakes another processor with the fixed three-command sequence: an INIT command, a short gap, a start-up command, a long gap, and a second identical start-up command. Each command is issued as a pair of 32-bit writes into an interrupt command register. The high word carries the destination and goes first. The low word carries the delivery mode, vector, level and shorthand fields, and writing it launches the command. After each launch the block polls a delivery-status input from the interrupt fabric. It does not move on until that input reads idle.

A request gives a target ID, a start address and a broadcast select. In broadcast mode the command goes to every processor except the requester. The start address must lie below 1 MiB on a 4 KiB boundary, and its page number becomes the start-up vector. A bad address is refused with a one-cycle error pulse.

Command words leave on a valid/ready port. Valid rises with a word and stays up, with data and word select held, until ready is seen high at a clock edge. Ready may stay low for any number of cycles. Start, status and delivery status are plain level or pulse pins.

Top module: `ipi_wake_seq`

## Requirements
- R1: A start pulse while idle whose address is 0x100000 or higher, or has any of bits 11:0 set, raises err_o for exactly one cycle, starting the cycle after the start edge. busy_o stays 0 and no command word is offered.
- R2: An accepted request produces exactly three commands: INIT, then start-up, then start-up. Each command is two accepted writes: first the high word (cmd_hi_o=1), then the low word (cmd_hi_o=0), with the low word offered in the cycle after the high word is accepted.
- R3: The high word holds the target ID in bits 31:24 and zeros elsewhere. In broadcast mode the whole high word is zero.
- R4: In the low word, bit 14 (level) is 1 and bits 10:8 hold the delivery mode: 3'b101 for INIT with vector bits 7:0 zero, and 3'b110 for start-up with bits 7:0 equal to address bits 19:12. Bits 19:18 are 2'b11 in broadcast mode and 2'b00 otherwise. All other bits are 0.
- R5: After each low word is accepted, no further word is offered and done_o does not rise while dlv_pend_i is sampled high. Polling begins at the first edge after the low-word acceptance.
- R6: The start-up high word is first offered exactly SHORT_DLY_CYC cycles after the first edge at which the INIT command's delivery status is sampled idle (SHORT_DLY_CYC >= 1; default CLK_MHZ*10).
- R7: The second start-up high word is first offered exactly LONG_DLY_CYC cycles after the first edge at which the first start-up's delivery status is sampled idle (LONG_DLY_CYC >= 1; default CLK_MHZ*200).
- R8: While cmd_valid_o is high and cmd_ready_i low, cmd_valid_o, cmd_hi_o and cmd_data_o hold their values into the next cycle.
- R9: done_o pulses for one cycle, in the cycle after the edge at which the last command's delivery status is sampled idle, and busy_o is 0 from that cycle on.
- R10: busy_o is 1 from the cycle after an accepted start until done_o. A start pulse while busy is ignored: the words sent keep the ID, address and mode latched at the accepted start, and exactly six words are sent.
- R11: After reset, busy_o, done_o, err_o and cmd_valid_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Request pulse, taken only while idle |
| target_id_i | input | ID_W | Destination processor ID |
| start_addr_i | input | ADDR_W | Physical start address of the woken processor |
| bcast_i | input | 1 | 1: send to all processors except self |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle pulse at sequence completion |
| err_o | output | 1 | One-cycle pulse on a rejected address |
| cmd_valid_o | output | 1 | Command word offered |
| cmd_ready_i | input | 1 | Command register accepts the word |
| cmd_hi_o | output | 1 | 1: high word, 0: low (launching) word |
| cmd_data_o | output | 32 | Command word |
| dlv_pend_i | input | 1 | Delivery status from the fabric, 1 = still pending |

## Verification
The bench builds the block with SHORT_DLY_CYC=4 and LONG_DLY_CYC=9. At the default gap lengths each sequence would take tens of thousands of cycles; the short gaps make cycle-exact checks of both gaps practical over a sweep of all 256 start-up vectors. Each run pairs its vector with its own target ID and broadcast choice, a delivery-pending length of 0 to 3 cycles and a ready stall of 0 to 2 cycles per word. This covers every field value of the vector and both shorthand encodings, with and without back-pressure. A set of addresses just past the 1 MiB limit, unaligned by one bit or far out of range checks the rejection path.

// File: rtl/ipi_wake_pkg.sv
`timescale 1ns/1ps
package ipi_wake_pkg;
  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_HI,
    SQ_LO,
    SQ_POLL,
    SQ_WAIT
  } sq_state_t;

  localparam int WORD_W    = 32;
  localparam int CMD_COUNT = 3;

  // low-word field positions
  localparam int VEC_LSB = 0;
  localparam int DM_LSB  = 8;
  localparam int DM_W    = 3;
  localparam int LVL_BIT = 14;
  localparam int SH_LSB  = 18;
  localparam int SH_W    = 2;
  // high-word field position
  localparam int ID_LSB  = 24;

  localparam logic [DM_W-1:0] DM_INIT  = 3'b101;
  localparam logic [DM_W-1:0] DM_START = 3'b110;
  localparam logic [SH_W-1:0] SH_NONE   = 2'b00;
  localparam logic [SH_W-1:0] SH_OTHERS = 2'b11;
endpackage

// File: rtl/ipi_addr_chk.sv
`timescale 1ns/1ps
module ipi_addr_chk #(
  parameter int ADDR_W    = 32,
  parameter int ADDR_TOP  = 20,
  parameter int PAGE_BITS = 12,
  localparam int VEC_W    = ADDR_TOP - PAGE_BITS
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic              ok_o,
  output logic [VEC_W-1:0]  vec_o
);
  logic below_limit;
  logic page_aligned;

  assign below_limit  = (addr_i[ADDR_W-1:ADDR_TOP] == '0);
  assign page_aligned = (addr_i[PAGE_BITS-1:0] == '0);
  assign ok_o         = below_limit && page_aligned;
  assign vec_o        = addr_i[ADDR_TOP-1:PAGE_BITS];
endmodule

// File: rtl/ipi_cmd_fmt.sv
`timescale 1ns/1ps
module ipi_cmd_fmt
  import ipi_wake_pkg::*;
#(
  parameter int ID_W  = 8,
  parameter int VEC_W = 8
) (
  input  logic [1:0]        step_i,
  input  logic              bcast_i,
  input  logic [ID_W-1:0]   id_i,
  input  logic [VEC_W-1:0]  vec_i,
  output logic [WORD_W-1:0] hi_word_o,
  output logic [WORD_W-1:0] lo_word_o
);
  always_comb begin
    hi_word_o = '0;
    if (!bcast_i) hi_word_o[ID_LSB +: ID_W] = id_i;

    lo_word_o = '0;
    lo_word_o[LVL_BIT] = 1'b1;
    if (step_i == 2'd0) begin
      lo_word_o[DM_LSB +: DM_W] = DM_INIT;
    end else begin
      lo_word_o[DM_LSB +: DM_W]   = DM_START;
      lo_word_o[VEC_LSB +: VEC_W] = vec_i;
    end
    lo_word_o[SH_LSB +: SH_W] = bcast_i ? SH_OTHERS : SH_NONE;
  end
endmodule

// File: rtl/ipi_gap_timer.sv
`timescale 1ns/1ps
module ipi_gap_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             expired_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)             cnt_q <= '0;
    else if (load_i)        cnt_q <= load_val_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign expired_o = (cnt_q == '0);

  assert_reload_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && load_val_i != '0) |=> !expired_o);
endmodule

// File: rtl/ipi_wake_seq.sv
`timescale 1ns/1ps
module ipi_wake_seq
  import ipi_wake_pkg::*;
#(
  parameter int CLK_MHZ       = 200,
  parameter int SHORT_DLY_CYC = CLK_MHZ * 10,
  parameter int LONG_DLY_CYC  = CLK_MHZ * 200,
  parameter int ID_W          = 8,
  parameter int ADDR_W        = 32,
  parameter int ADDR_TOP      = 20,
  parameter int PAGE_BITS     = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [ID_W-1:0]   target_id_i,
  input  logic [ADDR_W-1:0] start_addr_i,
  input  logic              bcast_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o,
  output logic              cmd_valid_o,
  input  logic              cmd_ready_i,
  output logic              cmd_hi_o,
  output logic [31:0]       cmd_data_o,
  input  logic              dlv_pend_i
);
  localparam int VEC_W   = ADDR_TOP - PAGE_BITS;
  localparam int GAP_MAX = (LONG_DLY_CYC > SHORT_DLY_CYC) ? LONG_DLY_CYC : SHORT_DLY_CYC;
  localparam int GAP_W   = $clog2(GAP_MAX + 1);
  localparam logic [1:0] LAST_STEP = 2'(CMD_COUNT - 1);
  localparam logic [GAP_W-1:0] SHORT_LOAD = GAP_W'(SHORT_DLY_CYC - 1);
  localparam logic [GAP_W-1:0] LONG_LOAD  = GAP_W'(LONG_DLY_CYC - 1);

  sq_state_t         state_q;
  logic [1:0]        step_q;
  logic [ID_W-1:0]   id_q;
  logic [VEC_W-1:0]  vec_q;
  logic              bc_q;
  logic              done_q;
  logic              err_q;

  logic              addr_ok;
  logic [VEC_W-1:0]  addr_vec;
  logic [WORD_W-1:0] hi_word;
  logic [WORD_W-1:0] lo_word;
  logic              gap_load;
  logic [GAP_W-1:0]  gap_val;
  logic              gap_done;
  logic              idle_seen;

  ipi_addr_chk #(
    .ADDR_W(ADDR_W), .ADDR_TOP(ADDR_TOP), .PAGE_BITS(PAGE_BITS)
  ) addr_chk_i (
    .addr_i(start_addr_i), .ok_o(addr_ok), .vec_o(addr_vec)
  );

  ipi_cmd_fmt #(
    .ID_W(ID_W), .VEC_W(VEC_W)
  ) cmd_fmt_i (
    .step_i(step_q), .bcast_i(bc_q), .id_i(id_q), .vec_i(vec_q),
    .hi_word_o(hi_word), .lo_word_o(lo_word)
  );

  assign idle_seen = (state_q == SQ_POLL) && !dlv_pend_i;
  assign gap_load  = idle_seen && (step_q != LAST_STEP);
  assign gap_val   = (step_q == 2'd0) ? SHORT_LOAD : LONG_LOAD;

  ipi_gap_timer #(
    .CNT_W(GAP_W)
  ) gap_timer_i (
    .clk(clk), .rst_n(rst_n), .load_i(gap_load), .load_val_i(gap_val),
    .expired_o(gap_done)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= SQ_IDLE;
      step_q  <= '0;
      id_q    <= '0;
      vec_q   <= '0;
      bc_q    <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      case (state_q)
        SQ_IDLE: begin
          if (start_i) begin
            if (addr_ok) begin
              state_q <= SQ_HI;
              step_q  <= '0;
              id_q    <= target_id_i;
              vec_q   <= addr_vec;
              bc_q    <= bcast_i;
            end else begin
              err_q <= 1'b1;
            end
          end
        end
        SQ_HI:   if (cmd_ready_i) state_q <= SQ_LO;
        SQ_LO:   if (cmd_ready_i) state_q <= SQ_POLL;
        SQ_POLL: begin
          if (idle_seen) begin
            if (step_q == LAST_STEP) begin
              state_q <= SQ_IDLE;
              done_q  <= 1'b1;
            end else begin
              state_q <= SQ_WAIT;
            end
          end
        end
        SQ_WAIT: begin
          if (gap_done) begin
            state_q <= SQ_HI;
            step_q  <= step_q + 2'd1;
          end
        end
        default: state_q <= SQ_IDLE;
      endcase
    end
  end

  assign busy_o      = (state_q != SQ_IDLE);
  assign done_o      = done_q;
  assign err_o       = err_q;
  assign cmd_valid_o = (state_q == SQ_HI) || (state_q == SQ_LO);
  assign cmd_hi_o    = (state_q == SQ_HI);
  assign cmd_data_o  = cmd_hi_o ? hi_word : lo_word;

  // gap measuring counter for the checks below
  logic [GAP_W:0] wait_cnt;
  always_ff @(posedge clk) begin
    if (!rst_n)                    wait_cnt <= '0;
    else if (state_q == SQ_POLL)   wait_cnt <= '0;
    else if (state_q == SQ_WAIT)   wait_cnt <= wait_cnt + 1'b1;
  end

  assert_err_pulse_R1: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |=> !err_o);
  assert_err_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> (!busy_o && !cmd_valid_o));
  assert_word_order_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid_o && cmd_ready_i && cmd_hi_o) |=> (cmd_valid_o && !cmd_hi_o));
  assert_hi_fields_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid_o && cmd_hi_o) |-> (cmd_data_o[ID_LSB-1:0] == '0));
  assert_lo_fields_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid_o && !cmd_hi_o) |-> (cmd_data_o[LVL_BIT] &&
      (cmd_data_o[DM_LSB +: DM_W] == DM_INIT || cmd_data_o[DM_LSB +: DM_W] == DM_START)));
  assert_poll_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SQ_POLL && dlv_pend_i) |=> (!cmd_valid_o && !done_o));
  assert_short_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(cmd_valid_o) && step_q == 2'd1) |-> (int'(wait_cnt) == SHORT_DLY_CYC));
  assert_long_gap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(cmd_valid_o) && step_q == 2'd2) |-> (int'(wait_cnt) == LONG_DLY_CYC));
  assert_hold_stall_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid_o && !cmd_ready_i) |=>
      (cmd_valid_o && $stable(cmd_hi_o) && $stable(cmd_data_o)));
  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  assert_done_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);
endmodule

// File: tb/ipi_wake_seq_tb_top.sv
`timescale 1ns/1ps
module ipi_wake_seq_tb_top;
  localparam int SHORT = 4;
  localparam int LONG  = 9;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [7:0]  tid = '0;
  logic [31:0] saddr = '0;
  logic        bc = 1'b0;
  logic        busy, done, err, cvalid, chi;
  logic        cready = 1'b0;
  logic [31:0] cdata;
  logic        pend;

  always #2.5 clk = ~clk;

  ipi_wake_seq #(.SHORT_DLY_CYC(SHORT), .LONG_DLY_CYC(LONG)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start), .target_id_i(tid),
    .start_addr_i(saddr), .bcast_i(bc), .busy_o(busy), .done_o(done),
    .err_o(err), .cmd_valid_o(cvalid), .cmd_ready_i(cready), .cmd_hi_o(chi),
    .cmd_data_o(cdata), .dlv_pend_i(pend)
  );

  int tests = 0;
  int fails = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // fabric and command register model, driven at the falling edge
  int          p_cfg = 0, s_cfg = 0;
  int          scnt = 0, pcnt = 0;
  logic        vprev = 1'b0;
  int          nlog = 0, nrise = 0, nlo = 0, ndone = 0, nerr = 0, done_c = 0;
  logic [31:0] log_d [8];
  logic        log_h [8];
  int          rise_c [4];
  int          lo_c [4];

  assign pend = (pcnt != 0);

  always @(negedge clk) begin
    if (pcnt > 0) pcnt = pcnt - 1;
    if (cvalid) begin
      if (scnt < s_cfg) begin cready = 1'b0; scnt = scnt + 1; end
      else cready = 1'b1;
    end else begin
      cready = 1'b0;
    end
    if (cvalid && !vprev) begin
      if (nrise < 4) rise_c[nrise] = cyc;
      nrise = nrise + 1;
    end
    vprev = cvalid;
    if (cvalid && cready) begin
      if (nlog < 8) begin log_d[nlog] = cdata; log_h[nlog] = chi; end
      nlog = nlog + 1;
      scnt = 0;
      if (!chi) begin
        if (nlo < 4) lo_c[nlo] = cyc;
        nlo = nlo + 1;
        pcnt = p_cfg + 1;
      end
    end
    if (done) begin done_c = cyc; ndone = ndone + 1; end
    if (err) nerr = nerr + 1;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic clear_log();
    nlog = 0; nrise = 0; nlo = 0; ndone = 0; nerr = 0;
  endtask

  task automatic run_valid(input int v);
    logic [31:0] a;
    logic [7:0]  id;
    logic        b;
    logic [31:0] exp_hi, exp_lo;
    int          waited;
    a  = 32'(v) << 12;
    id = 8'(v) ^ 8'hA5;
    b  = v[0] ^ v[3];
    p_cfg = v % 4;
    s_cfg = (v / 4) % 3;
    clear_log();
    tid = id; saddr = a; bc = b; start = 1'b1;
    step();
    start = 1'b0;
    chk("R10 busy after start", 32'(busy), 32'd1);
    chk("R1 no error on valid address", 32'(err), 32'd0);
    step(); step();
    // request while busy, must be ignored
    tid = ~id; saddr = 32'h0005_5000; bc = ~b; start = 1'b1;
    step();
    start = 1'b0;
    waited = 0;
    while (ndone == 0 && waited < 600) begin step(); waited++; end
    chk("R9 done seen", 32'(ndone), 32'd1);
    chk("R9 done one cycle", 32'(done), 32'd0);
    chk("R9 busy low after done", 32'(busy), 32'd0);
    chk("R10 six words sent", 32'(nlog), 32'd6);
    chk("R1 no error during run", 32'(nerr), 32'd0);
    exp_hi = b ? 32'h0 : {id, 24'h0};
    for (int k = 0; k < 3; k++) begin
      exp_lo = 32'h0000_4000 | (b ? 32'h000C_0000 : 32'h0);
      exp_lo = exp_lo | ((k == 0) ? 32'h0000_0500 : (32'h0000_0600 | 32'(v)));
      if (nlog >= 2 * k + 2) begin
        chk("R2 high word first", 32'(log_h[2*k]), 32'd1);
        chk("R2 low word second", 32'(log_h[2*k+1]), 32'd0);
        chk("R3 high word", log_d[2*k], exp_hi);
        chk("R4 low word", log_d[2*k+1], exp_lo);
      end
    end
    if (nlo >= 3 && nrise >= 3) begin
      chk("R6 short gap", 32'(rise_c[1] - lo_c[0]), 32'(p_cfg + 2 + SHORT));
      chk("R7 long gap", 32'(rise_c[2] - lo_c[1]), 32'(p_cfg + 2 + LONG));
      chk("R5 poll before done", 32'(done_c - lo_c[2]), 32'(p_cfg + 2));
    end
    step();
  endtask

  task automatic run_bad(input logic [31:0] a);
    clear_log();
    p_cfg = 0; s_cfg = 0;
    tid = 8'h3C; saddr = a; bc = 1'b0; start = 1'b1;
    step();
    start = 1'b0;
    chk("R1 error raised", 32'(err), 32'd1);
    chk("R1 not busy", 32'(busy), 32'd0);
    step();
    chk("R1 error one cycle", 32'(err), 32'd0);
    repeat (8) step();
    chk("R1 no words sent", 32'(nlog), 32'd0);
    chk("R1 still idle", 32'(busy), 32'd0);
  endtask

  initial begin
    repeat (3) step();
    chk("R11 busy in reset", 32'(busy), 32'd0);
    chk("R11 done in reset", 32'(done), 32'd0);
    chk("R11 err in reset", 32'(err), 32'd0);
    chk("R11 valid in reset", 32'(cvalid), 32'd0);
    rst_n = 1'b1;
    step();
    chk("R11 idle after reset", 32'(busy), 32'd0);
    for (int v = 0; v < 256; v++) run_valid(v);
    run_bad(32'h0010_0000);
    run_bad(32'h001F_F000);
    run_bad(32'hFFFF_F000);
    run_bad(32'h8000_0000);
    run_bad(32'h0000_0001);
    run_bad(32'h0000_0800);
    run_bad(32'h0000_0FFF);
    run_bad(32'h0001_2345);
    run_valid(255);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog actual=%0d expected=done", cyc);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule